// File: doc/BRIEF.md
# Fixed-Point Triangular Membership Evaluator

This block grades how strongly one unsigned fixed-point sample belongs to a triangular fuzzy set. The triangle has three breakpoints, left foot, apex and right foot, that are set by parameters. The sample and the breakpoints are 10 bits wide, with 3 integer bits and 7 fraction bits. The block returns an 11-bit degree in the same fraction scale, so full membership reads 128.

A caller presents a sample together with a one-cycle start pulse. The block first sorts the sample into one of four regions. The region is the apex point, the rising edge, the falling edge, or outside the support. Outside and apex results need no arithmetic and come back on the next clock edge. A sample on either edge builds a numerator pre-shifted by 7 bits and hands it, with the slope width as divisor, to a restoring divider that yields one quotient bit per clock. A one-cycle done pulse marks each result, and the degree register holds that result until the next completion.

The control is a two-state machine. State ST_IDLE accepts start. It moves to ST_DIVIDE when the sample lies on a slope, and otherwise stays in ST_IDLE while writing the degree directly. State ST_DIVIDE waits for the divider to finish, writes the quotient, and returns to ST_IDLE. Because division is only launched for samples strictly inside a slope, a slope of zero width never reaches the divider.

Top module: `tri_member_eval`

## Requirements
- R1: A sample x that is not equal to the apex and satisfies x ≤ left foot or x ≥ right foot yields degree 0.
- R2: A sample equal to the apex yields degree 128 (binary 000_1000_0000). This holds also when the apex coincides with either foot.
- R3: For left foot < x < apex the degree is floor((x − left foot)·128 / (apex − left foot)).
- R4: For apex < x < right foot the degree is floor((right foot − x)·128 / (right foot − apex)).
- R5: Count the edge that samples start as edge 1. Outside and apex results raise done on edge 1. Slope results raise done on edge 19: one load edge, 17 divider steps and one write edge.
- R6: done is high for exactly one cycle per accepted start and never while a division is in progress.
- R7: A start that arrives while a division is in progress is ignored and neither changes nor adds a result.
- R8: The degree output keeps its value in every cycle in which done is low.
- R9: The divider is never loaded with a zero divisor, and no degree exceeds 128.
- R10: A synchronous active-high reset returns the machine to ST_IDLE, drops done and clears the degree to 0, abandoning any division in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to evaluate x_i |
| x_i | input | 10 | Sample, unsigned, 7 fraction bits |
| done_o | output | 1 | One-cycle pulse when deg_o is updated |
| deg_o | output | 11 | Membership degree, 128 means full membership |

## Verification
The stimulus aims at the exact breakpoints and at the samples one step inside each foot and each side of the apex. At those points, an off-by-one region compare would return a slope fraction where 0 or 128 is due, or the reverse. Two extra instances with a collapsed slope, apex equal to the right foot and apex equal to the left foot, show whether the apex is given full membership or is instead sent to a divider with divisor zero. A start pulse injected mid-division would, in a design that accepts it, produce a second done or replace the slope result with 128. A reset during division would, if the divider is not cleared, let a late done escape. Latency is timed per result, so a divider that runs one step too few or too many shows up even when its quotient happens to be right.

// File: rtl/tmf_pkg.sv
`timescale 1ns/1ps
package tmf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1
    } tmf_state_e;

    typedef enum logic [1:0] {
        RG_OUTSIDE = 2'd0,
        RG_PEAK    = 2'd1,
        RG_RISE    = 2'd2,
        RG_FALL    = 2'd3
    } tmf_region_e;

endpackage

// File: rtl/tmf_region.sv
`timescale 1ns/1ps
// Sorts a sample into a triangle region and forms the scaled numerator and
// the slope width. The divisor is only non-zero for samples strictly inside
// a slope, so a collapsed slope can never produce a divide request.
module tmf_region
    import tmf_pkg::*;
#(
    parameter int                IN_W   = 10,
    parameter int                FRAC_W = 7,
    parameter logic [IN_W-1:0]   A_PT   = 10'd346,
    parameter logic [IN_W-1:0]   B_PT   = 10'd429,
    parameter logic [IN_W-1:0]   C_PT   = 10'd512
) (
    input  logic [IN_W-1:0]        x_i,
    output tmf_region_e            kind_o,
    output logic [IN_W+FRAC_W-1:0] num_o,
    output logic [IN_W-1:0]        den_o
);
    logic [IN_W-1:0] span;

    always_comb begin
        kind_o = RG_OUTSIDE;
        span   = '0;
        den_o  = '0;
        if (x_i == B_PT) begin
            kind_o = RG_PEAK;
        end else if ((x_i > A_PT) && (x_i < B_PT)) begin
            kind_o = RG_RISE;
            span   = x_i - A_PT;
            den_o  = B_PT - A_PT;
        end else if ((x_i > B_PT) && (x_i < C_PT)) begin
            kind_o = RG_FALL;
            span   = C_PT - x_i;
            den_o  = C_PT - B_PT;
        end
        num_o = {span, {FRAC_W{1'b0}}};
    end

endmodule

// File: rtl/tmf_divider.sv
`timescale 1ns/1ps
// Restoring shift-subtract divider, one quotient bit per clock.
module tmf_divider #(
    parameter int NUM_W  = 17,
    parameter int DEN_W  = 10,
    parameter int QUOT_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [DEN_W-1:0]  den_i,
    output logic              valid_o,
    output logic [QUOT_W-1:0] quot_o
);
    localparam int                CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0]  STEPS = CNT_W'(NUM_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(1);

    logic [NUM_W-1:0]  num_q;
    logic [DEN_W-1:0]  den_q;
    logic [DEN_W-1:0]  rem_q;
    logic [QUOT_W-1:0] quot_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              running_q;
    logic              valid_q;

    logic [DEN_W:0]    rem_sh;
    logic              fits;

    always_comb begin
        rem_sh = {rem_q, num_q[NUM_W-1]};
        fits   = (rem_sh >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q     <= '0;
            den_q     <= '0;
            rem_q     <= '0;
            quot_q    <= '0;
            cnt_q     <= '0;
            running_q <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (load_i) begin
                num_q     <= num_i;
                den_q     <= den_i;
                rem_q     <= '0;
                quot_q    <= '0;
                cnt_q     <= STEPS;
                running_q <= 1'b1;
            end else if (running_q) begin
                num_q  <= num_q << 1;
                quot_q <= {quot_q[QUOT_W-2:0], fits};
                rem_q  <= fits ? DEN_W'(rem_sh - {1'b0, den_q}) : DEN_W'(rem_sh);
                cnt_q  <= cnt_q - LAST;
                if (cnt_q == LAST) begin
                    running_q <= 1'b0;
                    valid_q   <= 1'b1;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign quot_o  = quot_q;

endmodule

// File: rtl/tri_member_eval.sv
`timescale 1ns/1ps
module tri_member_eval
    import tmf_pkg::*;
#(
    parameter int                IN_W   = 10,
    parameter int                FRAC_W = 7,
    parameter int                DEG_W  = 11,
    parameter logic [IN_W-1:0]   A_PT   = 10'd346,
    parameter logic [IN_W-1:0]   B_PT   = 10'd429,
    parameter logic [IN_W-1:0]   C_PT   = 10'd512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [IN_W-1:0]  x_i,
    output logic             done_o,
    output logic [DEG_W-1:0] deg_o
);
    localparam int               NUM_W = IN_W + FRAC_W;
    localparam logic [DEG_W-1:0] FULL  = DEG_W'(1) << FRAC_W;

    tmf_state_e        state_q, state_d;
    tmf_region_e       kind;
    logic [NUM_W-1:0]  num;
    logic [IN_W-1:0]   den;
    logic              accept;
    logic              div_load;
    logic              div_valid;
    logic [DEG_W-1:0]  quot;
    logic              busy;
    logic              done_q;
    logic [DEG_W-1:0]  deg_q;

    tmf_region #(
        .IN_W   (IN_W),
        .FRAC_W (FRAC_W),
        .A_PT   (A_PT),
        .B_PT   (B_PT),
        .C_PT   (C_PT)
    ) u_region (
        .x_i    (x_i),
        .kind_o (kind),
        .num_o  (num),
        .den_o  (den)
    );

    assign busy     = (state_q == ST_DIVIDE);
    assign accept   = start_i && (state_q == ST_IDLE);
    assign div_load = accept && ((kind == RG_RISE) || (kind == RG_FALL));

    tmf_divider #(
        .NUM_W  (NUM_W),
        .DEN_W  (IN_W),
        .QUOT_W (DEG_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .load_i  (div_load),
        .num_i   (num),
        .den_i   (den),
        .valid_o (div_valid),
        .quot_o  (quot)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (div_load)  state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_valid) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            deg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && (kind == RG_OUTSIDE)) begin
                        deg_q  <= '0;
                        done_q <= 1'b1;
                    end else if (accept && (kind == RG_PEAK)) begin
                        deg_q  <= FULL;
                        done_q <= 1'b1;
                    end
                end
                ST_DIVIDE: begin
                    if (div_valid) begin
                        deg_q  <= quot;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done_o = done_q;
    assign deg_o  = deg_q;

endmodule

// File: rtl/tri_member_eval_chk.sv
`timescale 1ns/1ps
module tri_member_eval_chk #(
    parameter int                IN_W   = 10,
    parameter int                FRAC_W = 7,
    parameter int                DEG_W  = 11,
    parameter logic [IN_W-1:0]   A_PT   = 10'd346,
    parameter logic [IN_W-1:0]   B_PT   = 10'd429,
    parameter logic [IN_W-1:0]   C_PT   = 10'd512
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [IN_W-1:0]  x_i,
    input logic             done_o,
    input logic [DEG_W-1:0] deg_o,
    input logic             busy,
    input logic             div_load,
    input logic [IN_W-1:0]  div_den
);
    localparam logic [DEG_W-1:0] FULL = DEG_W'(1) << FRAC_W;

    assert_outside_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy && (x_i != B_PT) && ((x_i <= A_PT) || (x_i >= C_PT)))
        |=> (done_o && (deg_o == '0)));

    assert_peak_full_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy && (x_i == B_PT)) |=> (done_o && (deg_o == FULL)));

    assert_no_done_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done_o);

    assert_hold_deg_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(deg_o));

    assert_div_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        div_load |-> (div_den != '0));

    assert_deg_range_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (deg_o <= FULL));

endmodule

bind tri_member_eval tri_member_eval_chk #(
    .IN_W   (IN_W),
    .FRAC_W (FRAC_W),
    .DEG_W  (DEG_W),
    .A_PT   (A_PT),
    .B_PT   (B_PT),
    .C_PT   (C_PT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .x_i      (x_i),
    .done_o   (done_o),
    .deg_o    (deg_o),
    .busy     (busy),
    .div_load (div_load),
    .div_den  (den)
);

// File: tb/tb_tri_member_eval.sv
`timescale 1ns/1ps
module tb_tri_member_eval;

    localparam int A_M = 346, B_M = 429, C_M = 512;
    localparam int A_H = 0,   B_H = 128, C_H = 128;
    localparam int A_L = 256, B_L = 256, C_L = 384;
    localparam int LAT_SHORT = 1;
    localparam int LAT_DIV   = 1 + 17 + 1;

    typedef struct {
        int    deg;
        int    c0;
        int    lat;
        string req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_m = 1'b0, start_h = 1'b0, start_l = 1'b0;
    logic [9:0]  x_m = '0, x_h = '0, x_l = '0;
    logic        done_m, done_h, done_l;
    logic [10:0] deg_m, deg_h, deg_l;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 0;
    sb_item_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tri_member_eval #(.A_PT(10'(A_M)), .B_PT(10'(B_M)), .C_PT(10'(C_M))) dut (
        .clk(clk), .rst(rst), .start_i(start_m), .x_i(x_m), .done_o(done_m), .deg_o(deg_m));
    tri_member_eval #(.A_PT(10'(A_H)), .B_PT(10'(B_H)), .C_PT(10'(C_H))) dut_hi (
        .clk(clk), .rst(rst), .start_i(start_h), .x_i(x_h), .done_o(done_h), .deg_o(deg_h));
    tri_member_eval #(.A_PT(10'(A_L)), .B_PT(10'(B_L)), .C_PT(10'(C_L))) dut_lo (
        .clk(clk), .rst(rst), .start_i(start_l), .x_i(x_l), .done_o(done_l), .deg_o(deg_l));

    function automatic int exp_deg(int a, int b, int c, int x);
        if (x == b) return 128;
        if (x <= a || x >= c) return 0;
        if (x < b) return ((x - a) * 128) / (b - a);
        return ((c - x) * 128) / (c - b);
    endfunction

    function automatic int exp_lat(int a, int b, int c, int x);
        if (x == b || x <= a || x >= c) return LAT_SHORT;
        return LAT_DIV;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected items as results appear on the main instance.
    always @(negedge clk) begin
        if (!rst && done_m) begin
            if (q.size() == 0) begin
                check("R6 unexpected done", 1, 0);
            end else begin
                sb_item_t it;
                it = q.pop_front();
                check({it.req, " degree"}, int'(deg_m), it.deg);
                check({"R5 latency for ", it.req}, cyc - it.c0, it.lat);
            end
        end
    end

    // Driver for the main instance: pushes the expected result, then starts.
    task automatic send(int x, string req);
        sb_item_t it;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        it.deg = exp_deg(A_M, B_M, C_M, x);
        it.lat = exp_lat(A_M, B_M, C_M, x);
        it.c0  = cyc;
        it.req = req;
        q.push_back(it);
        start_m = 1'b1;
        x_m     = 10'(x);
        @(negedge clk);
        start_m = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (q.size() != 0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R6 all results delivered", q.size(), 0);
    endtask

    // Direct check of a degenerate-slope instance (0 = apex at right foot).
    task automatic side(int which, int x, string req);
        int exp;
        int got;
        bit seen;
        seen = 0;
        got  = -1;
        exp  = (which == 0) ? exp_deg(A_H, B_H, C_H, x) : exp_deg(A_L, B_L, C_L, x);
        @(negedge clk);
        if (which == 0) begin start_h = 1'b1; x_h = 10'(x); end
        else            begin start_l = 1'b1; x_l = 10'(x); end
        @(negedge clk);
        start_h = 1'b0;
        start_l = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (which == 0 && done_h) begin seen = 1; got = int'(deg_h); end
            if (which == 1 && done_l) begin seen = 1; got = int'(deg_l); end
            if (!seen) @(negedge clk);
        end
        check({req, " degenerate slope"}, got, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 done after reset", int'(done_m), 0);
        check("R10 degree after reset", int'(deg_m), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: outside support
        send(0,    "R1 x=0");
        send(A_M,  "R1 x=left foot");
        send(C_M,  "R1 x=right foot");
        send(1023, "R1 x=max");
        // R2: apex
        send(B_M,  "R2 x=apex");
        // R3: rising slope
        send(A_M + 1, "R3 just above left foot");
        send(400,     "R3 mid rise");
        send(B_M - 1, "R3 just below apex");
        // R4: falling slope
        send(B_M + 1, "R4 just above apex");
        send(470,     "R4 mid fall");
        send(C_M - 1, "R4 just below right foot");
        // back-to-back shortcut results
        send(B_M, "R2 repeat apex");
        send(10,  "R1 repeat low");
        drain();

        // R7: start during a division is ignored
        send(400, "R7 slope under stray start");
        repeat (3) @(negedge clk);
        start_m = 1'b1;
        x_m     = 10'(B_M);
        @(negedge clk);
        start_m = 1'b0;
        drain();
        // R8: degree holds with done low
        repeat (6) @(negedge clk);
        check("R8 degree held", int'(deg_m), exp_deg(A_M, B_M, C_M, 400));
        check("R7 no extra done", int'(done_m), 0);

        // R2/R9: degenerate slopes
        side(0, B_H, "R2 apex equals right foot");
        side(0, 64,  "R3 rise before collapsed fall");
        side(0, 129, "R1 beyond collapsed fall");
        side(1, B_L, "R2 apex equals left foot");
        side(1, 255, "R1 below collapsed rise");
        side(1, 320, "R4 fall after collapsed rise");
        side(1, C_L, "R1 right foot");

        // R10: reset abandons a division
        @(negedge clk);
        start_m = 1'b1;
        x_m     = 10'(470);
        @(negedge clk);
        start_m = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R10 degree cleared by reset", int'(deg_m), 0);
        repeat (25) @(negedge clk);
        check("R10 no late done", int'(done_m), 0);
        check("R10 degree still cleared", int'(deg_m), 0);
        // machine usable after reset
        send(B_M + 1, "R4 after reset");
        drain();

        finish_run();
    end

endmodule